// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide parallel flash bus and the embedded program/erase controller. It watches write cycles on the bus. A write cycle is a strobe pulse taken while the chip is selected and the output driver is off. The block matches runs of writes against the fixed unlock sequences. When a sequence completes, it sends one request to the controller: byte program, whole-array erase, sector erase or boot-region lock. The controller carries out the operation and reports busy while it runs. The block also holds an identification mode. In that mode, reads at the lowest three addresses return two fixed code bytes and the boot lock flag.

The bus pins are asynchronous to the system clock. The block synchronises the qualified write strobe and rejects pulses shorter than a programmable number of clocks. It takes the address when the filtered strobe becomes active and the data when it ends. After reset, a counter blocks all controller requests until a set number of clocks has passed. Sequence tracking and identification mode work during that window.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `req_valid`, `id_mode` and `id_rd_hit` are 0.
- R2: A write cycle counts only when the strobe is low while chip select is low and output enable is high, for at least MIN_PULSE clocks. Shorter or unqualified pulses leave the tracker state unchanged.
- R3: Writing AA to 5555, 55 to 2AAA and A0 to 5555, then one more write, issues a request with `req_op` = 0 (program) and that write's full address and data. Only address bits 14..0 are compared against command addresses.
- R4: The prefix, then 80 to 5555, AA to 5555 and 55 to 2AAA, followed by a sixth write, issues one request. The sixth write selects the request: 10 to 5555 gives `req_op` = 1 (erase all); 30 to any address gives `req_op` = 2 (sector erase) with that full address in `req_addr`; 40 to 5555 gives `req_op` = 3 (lock boot region).
- R5: A write that does not match the expected address and data for the current step returns the tracker to idle and issues no request.
- R6: The prefix followed by 90 to 5555 sets `id_mode`.
- R7: While `id_mode` is 1, a read with chip select and output enable low updates `id_rd_hit` and `id_rd_data` on the next clock. Address 0 returns DA, address 1 returns 0B, address 2 returns `boot_locked` in bit 0 with the other bits 0. Any other address, or `id_mode` = 0, gives `id_rd_hit` = 0.
- R8: `id_mode` is cleared either by the prefix followed by F0 to 5555 or by a single write of F0 to any address.
- R9: No request is issued until POR_CYCLES clocks after reset. Identification mode entry still works in that window.
- R10: Writes that complete while `ctrl_busy` is 1 issue no request and return the tracker to idle.
- R11: `req_valid` is a pulse of a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8 | Bus write data |
| ctrl_busy | input | 1 | Embedded operation running |
| boot_locked | input | 1 | Current boot-region lock flag |
| req_valid | output | 1 | Request pulse to controller |
| req_op | output | 2 | 0 program, 1 erase all, 2 sector erase, 3 lock boot |
| req_addr | output | ADDR_W | Target or sector address |
| req_data | output | 8 | Program data |
| id_mode | output | 1 | Identification mode active |
| id_rd_hit | output | 1 | Identification read data valid |
| id_rd_data | output | 8 | Identification read byte |

## Verification
The bound checker watches several rules on every cycle. Requests come as single pulses and never follow a busy cycle. None appears inside the power-on window. Each rise or fall of identification mode follows an accepted write of 90 or F0. Program and sector requests trace back to an accepted write the cycle before. Only the bench scenarios show that the right sequences produce the right operation, address and data. They also show that wrong, blocked or too-short writes are ignored, and what the identification reads return. These scenarios sweep every possible third and sixth command byte and mismatch each step of a sequence in turn.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_LOCK = 2'd3
  } fc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ER3,
    ST_ER4,
    ST_ER5
  } fc_state_e;

  localparam int unsigned CMP_W = 15;
  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_A  = 8'hAA;
  localparam logic [7:0] KEY_DATA_B  = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_ID_ON  = 8'h90;
  localparam logic [7:0] CODE_ID_OFF = 8'hF0;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_LOCK   = 8'h40;
endpackage

// File: rtl/fc_strobe_filter.sv
module fc_strobe_filter #(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_din,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [7:0]        evt_data
);
  localparam int RUN_W = $clog2(MIN_PULSE + 1);
  localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(MIN_PULSE);

  logic                   raw_act;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   act;
  logic                   act_q;
  logic [RUN_W-1:0]       run_q;
  logic [ADDR_W-1:0]      addr_lat;

  assign raw_act = ~bus_we_n & ~bus_ce_n & bus_oe_n;
  assign act     = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      act_q     <= 1'b0;
      run_q     <= '0;
      addr_lat  <= '0;
      evt_valid <= 1'b0;
      evt_addr  <= '0;
      evt_data  <= '0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], raw_act};
      act_q     <= act;
      evt_valid <= 1'b0;
      if (act && !act_q) begin
        addr_lat <= bus_addr;
        run_q    <= RUN_W'(1);
      end else if (act && run_q < RUN_MIN) begin
        run_q <= run_q + RUN_W'(1);
      end
      if (!act && act_q) begin
        evt_valid <= (run_q >= RUN_MIN);
        evt_addr  <= addr_lat;
        evt_data  <= bus_din;
        run_q     <= '0;
      end
    end
  end
endmodule

// File: rtl/fc_por_timer.sv
module fc_por_timer #(
  parameter int POR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  output logic wr_ok
);
  localparam int CNT_W = (POR_CYCLES < 1) ? 1 : $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wr_ok <= 1'b0;
    end else begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
      wr_ok <= (cnt_q == LIMIT) || (cnt_q + CNT_W'(1) == LIMIT);
    end
  end
endmodule

// File: rtl/fc_seq_fsm.sv
module fc_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [7:0]        evt_data,
  input  logic              ctrl_busy,
  input  logic              wr_ok,
  output logic              req_valid,
  output fc_op_e            req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              id_mode
);
  fc_state_e state_q;
  logic at_a, at_b;
  logic key_a, key_b;

  assign at_a  = (evt_addr[CMP_W-1:0] == KEY_ADDR_A);
  assign at_b  = (evt_addr[CMP_W-1:0] == KEY_ADDR_B);
  assign key_a = at_a && (evt_data == KEY_DATA_A);
  assign key_b = at_b && (evt_data == KEY_DATA_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      id_mode   <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= OP_PROG;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (evt_valid) begin
        state_q <= ST_IDLE;
        if (!ctrl_busy) begin
          if (id_mode && evt_data == CODE_ID_OFF) begin
            id_mode <= 1'b0;
          end else begin
            unique case (state_q)
              ST_IDLE: if (key_a) state_q <= ST_UNL1;
              ST_UNL1: if (key_b) state_q <= ST_UNL2;
              ST_UNL2: begin
                if (at_a) begin
                  if (evt_data == CODE_PROG)  state_q <= ST_PGM;
                  if (evt_data == CODE_ERASE) state_q <= ST_ER3;
                  if (evt_data == CODE_ID_ON) id_mode <= 1'b1;
                end
              end
              ST_PGM: begin
                req_valid <= wr_ok;
                req_op    <= OP_PROG;
                req_addr  <= evt_addr;
                req_data  <= evt_data;
              end
              ST_ER3: if (key_a) state_q <= ST_ER4;
              ST_ER4: if (key_b) state_q <= ST_ER5;
              ST_ER5: begin
                req_addr <= evt_addr;
                req_data <= evt_data;
                if (evt_data == CODE_SECT) begin
                  req_valid <= wr_ok;
                  req_op    <= OP_SECT;
                end else if (at_a && evt_data == CODE_CHIP) begin
                  req_valid <= wr_ok;
                  req_op    <= OP_CHIP;
                end else if (at_a && evt_data == CODE_LOCK) begin
                  req_valid <= wr_ok;
                  req_op    <= OP_LOCK;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/fc_id_reader.sv
module fc_id_reader #(
  parameter int          ADDR_W   = 18,
  parameter logic [7:0]  MFR_CODE = 8'hDA,
  parameter logic [7:0]  DEV_CODE = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              boot_locked,
  output logic              id_rd_hit,
  output logic [7:0]        id_rd_data
);
  logic       low_addr;
  logic [7:0] sel_byte;

  assign low_addr = (bus_addr < ADDR_W'(3));

  always_comb begin
    unique case (bus_addr[1:0])
      2'd0:    sel_byte = MFR_CODE;
      2'd1:    sel_byte = DEV_CODE;
      default: sel_byte = {7'd0, boot_locked};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_rd_hit  <= 1'b0;
      id_rd_data <= '0;
    end else begin
      id_rd_hit  <= id_mode && !bus_ce_n && !bus_oe_n && low_addr;
      id_rd_data <= (id_mode && low_addr) ? sel_byte : 8'h00;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 18,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_PULSE   = 3,
  parameter int          POR_CYCLES  = 500000,
  parameter logic [7:0]  MFR_CODE    = 8'hDA,
  parameter logic [7:0]  DEV_CODE    = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_din,
  input  logic              ctrl_busy,
  input  logic              boot_locked,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic              id_mode,
  output logic              id_rd_hit,
  output logic [7:0]        id_rd_data
);
  logic              evt_valid;
  logic [ADDR_W-1:0] evt_addr;
  logic [7:0]        evt_data;
  logic              wr_ok;
  fc_op_e            op_int;

  fc_strobe_filter #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)
  ) u_filt (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  fc_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .wr_ok(wr_ok)
  );

  fc_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .evt_data(evt_data), .ctrl_busy(ctrl_busy), .wr_ok(wr_ok),
    .req_valid(req_valid), .req_op(op_int), .req_addr(req_addr),
    .req_data(req_data), .id_mode(id_mode)
  );

  assign req_op = op_int;

  fc_id_reader #(
    .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_id (
    .clk(clk), .rst(rst), .id_mode(id_mode), .bus_ce_n(bus_ce_n),
    .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .boot_locked(boot_locked),
    .id_rd_hit(id_rd_hit), .id_rd_data(id_rd_data)
  );
endmodule

// File: rtl/fc_decoder_chk.sv
module fc_decoder_chk #(
  parameter int POR_CYCLES = 500000
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_busy,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       id_mode,
  input logic       id_rd_hit,
  input logic       evt_valid,
  input logic [7:0] evt_data
);
  localparam int CW = $clog2(POR_CYCLES + 2) + 1;
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst <= CW'(POR_CYCLES)) since_rst <= since_rst + CW'(1);
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  a_r10_no_req_after_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$past(ctrl_busy));

  a_r9_por_window: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (since_rst > CW'(POR_CYCLES)));

  a_r6_id_entry_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(evt_valid && evt_data == 8'h90));

  a_r8_id_exit_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(id_mode) |-> $past(evt_valid && evt_data == 8'hF0));

  a_r7_hit_needs_mode: assert property (@(posedge clk) disable iff (rst)
    id_rd_hit |-> $past(id_mode));

  a_r3_prog_from_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd0) |-> $past(evt_valid));

  a_r4_sector_code: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd2) |-> $past(evt_valid && evt_data == 8'h30));
endmodule

bind flash_cmd_decoder fc_decoder_chk #(.POR_CYCLES(POR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .ctrl_busy(ctrl_busy), .req_valid(req_valid),
  .req_op(req_op), .id_mode(id_mode), .id_rd_hit(id_rd_hit),
  .evt_valid(evt_valid), .evt_data(evt_data)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW  = 18;
  localparam int POR = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic busy = 1'b0, locked = 1'b0;
  logic req_valid, id_mode, id_rd_hit;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data, id_rd_data;

  int tests = 0, fails = 0;
  int req_cnt = 0, dbl_cnt = 0;
  logic prev_req = 1'b0;
  logic [1:0] last_op = '0;
  logic [AW-1:0] last_addr = '0;
  logic [7:0] last_data = '0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .SYNC_STAGES(2), .MIN_PULSE(3), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .ctrl_busy(busy), .boot_locked(locked),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .id_mode(id_mode), .id_rd_hit(id_rd_hit), .id_rd_data(id_rd_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid) begin
        req_cnt++;
        last_op = req_op; last_addr = req_addr; last_data = req_data;
        if (prev_req) dbl_cnt++;
      end
      prev_req = req_valid;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input int len = 4, input logic ce = 1'b0, input logic oe = 1'b1);
    @(negedge clk);
    addr = a; din = d; ce_n = ce; oe_n = oe;
    @(negedge clk);
    we_n = 1'b0;
    repeat (len) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix();
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
  endtask

  task automatic erase_pre();
    prefix();
    wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
  endtask

  task automatic id_rd(input logic [AW-1:0] a, output logic hit, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    hit = id_rd_hit; d = id_rd_data;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_req(input string tag, input int base, input logic [1:0] op,
                            input logic [AW-1:0] a, input logic [7:0] d, input bit chk_ad);
    check({tag, " count"}, req_cnt - base, 1);
    check({tag, " op"}, last_op, op);
    if (chk_ad) begin
      check({tag, " addr"}, last_addr, a);
      check({tag, " data"}, last_data, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    logic h;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 req_valid", req_valid, 0);
    check("R1 id_mode", id_mode, 0);
    check("R1 id_rd_hit", id_rd_hit, 0);

    // R9 requests blocked inside power-on window, ID still works
    base = req_cnt;
    prefix(); wr(18'h05555, 8'hA0); wr(18'h00100, 8'h12);
    check("R9 no req in window", req_cnt - base, 0);
    prefix(); wr(18'h05555, 8'h90);
    check("R9 id entry in window", id_mode, 1);
    wr(18'h00000, 8'hF0);
    repeat (POR) @(negedge clk);

    // R3 program, several patterns, upper address bits ignored in compare
    base = req_cnt; prefix(); wr(18'h05555, 8'hA0); wr(18'h3FFFF, 8'h00);
    expect_req("R3 prog top", base, 2'd0, 18'h3FFFF, 8'h00, 1);
    base = req_cnt; prefix(); wr(18'h05555, 8'hA0); wr(18'h00000, 8'hFF);
    expect_req("R3 prog zero", base, 2'd0, 18'h00000, 8'hFF, 1);
    base = req_cnt;
    wr(18'h35555, 8'hAA); wr(18'h12AAA, 8'h55); wr(18'h25555, 8'hA0); wr(18'h2AAAA, 8'h5A);
    expect_req("R3 high bits ignored", base, 2'd0, 18'h2AAAA, 8'h5A, 1);

    // R4 erase family
    base = req_cnt; erase_pre(); wr(18'h05555, 8'h10);
    expect_req("R4 chip", base, 2'd1, 18'h05555, 8'h10, 0);
    base = req_cnt; erase_pre(); wr(18'h05555, 8'h40);
    expect_req("R4 lock", base, 2'd3, 18'h05555, 8'h40, 0);
    base = req_cnt; erase_pre(); wr(18'h3A123, 8'h30);
    expect_req("R4 sector", base, 2'd2, 18'h3A123, 8'h30, 1);
    base = req_cnt; erase_pre(); wr(18'h3C000, 8'h30);
    expect_req("R4 sector boot", base, 2'd2, 18'h3C000, 8'h30, 1);

    // R5/R3/R6 sweep of the third command byte
    for (int d = 0; d < 256; d++) begin
      base = req_cnt;
      prefix(); wr(18'h05555, d[7:0]); wr(18'h01234, 8'h5A);
      if (d == 8'hA0) begin
        expect_req("R3 sweep", base, 2'd0, 18'h01234, 8'h5A, 1);
      end else begin
        check("R5 sweep3 no req", req_cnt - base, 0);
        check("R6 sweep3 id_mode", id_mode, (d == 8'h90) ? 1 : 0);
        if (id_mode) wr(18'h00000, 8'hF0);
      end
    end

    // R4/R5 sweep of the sixth command byte at the key address
    for (int d = 0; d < 256; d++) begin
      base = req_cnt;
      erase_pre(); wr(18'h05555, d[7:0]);
      if (d == 8'h10)      expect_req("R4 sweep chip", base, 2'd1, 18'h05555, 8'h10, 0);
      else if (d == 8'h30) expect_req("R4 sweep sector", base, 2'd2, 18'h05555, 8'h30, 1);
      else if (d == 8'h40) expect_req("R4 sweep lock", base, 2'd3, 18'h05555, 8'h40, 0);
      else check("R5 sweep6 no req", req_cnt - base, 0);
    end

    // R5 mismatch at each step of the erase sequence
    for (int k = 0; k < 5; k++) begin
      base = req_cnt;
      wr(18'h05555, (k == 0) ? 8'hAB : 8'hAA);
      wr((k == 1) ? 18'h02AAB : 18'h02AAA, 8'h55);
      wr(18'h05555, (k == 2) ? 8'h81 : 8'h80);
      wr((k == 3) ? 18'h05554 : 18'h05555, 8'hAA);
      wr(18'h02AAA, (k == 4) ? 8'h54 : 8'h55);
      wr(18'h05555, 8'h10);
      check("R5 mismatch step", req_cnt - base, 0);
      base = req_cnt; prefix(); wr(18'h05555, 8'hA0); wr(18'h00042, 8'h24);
      expect_req("R5 recover", base, 2'd0, 18'h00042, 8'h24, 1);
    end

    // R7/R8 identification reads and exits
    prefix(); wr(18'h05555, 8'h90);
    check("R6 enter", id_mode, 1);
    id_rd(18'h00000, h, rd); check("R7 hit0", h, 1); check("R7 mfr", rd, 8'hDA);
    id_rd(18'h00001, h, rd); check("R7 hit1", h, 1); check("R7 dev", rd, 8'h0B);
    locked = 1'b0;
    id_rd(18'h00002, h, rd); check("R7 lock0", rd, 8'h00);
    locked = 1'b1;
    id_rd(18'h00002, h, rd); check("R7 lock1", rd, 8'h01);
    id_rd(18'h00003, h, rd); check("R7 addr3 no hit", h, 0);
    id_rd(18'h10000, h, rd); check("R7 high addr no hit", h, 0);
    prefix(); wr(18'h05555, 8'hF0);
    check("R8 full exit", id_mode, 0);
    id_rd(18'h00000, h, rd); check("R7 no hit outside", h, 0);
    prefix(); wr(18'h05555, 8'h90);
    wr(18'h2BCDE, 8'hF0);
    check("R8 single exit", id_mode, 0);

    // R2 blocked and short strobes leave an armed program intact
    for (int c = 0; c < 4; c++) begin
      base = req_cnt;
      prefix(); wr(18'h05555, 8'hA0);
      case (c)
        0: wr(18'h00777, 8'h11, 4, 1'b1, 1'b1);
        1: wr(18'h00777, 8'h11, 4, 1'b0, 1'b0);
        2: wr(18'h00777, 8'h11, 1);
        default: wr(18'h00777, 8'h11, 2);
      endcase
      check("R2 blocked ignored", req_cnt - base, 0);
      wr(18'h00888, 8'h22, 3);
      expect_req("R2 min pulse accepted", base, 2'd0, 18'h00888, 8'h22, 1);
    end

    // R10 busy
    base = req_cnt;
    busy = 1'b1;
    prefix(); wr(18'h05555, 8'hA0); wr(18'h00300, 8'h33);
    busy = 1'b0;
    check("R10 busy no req", req_cnt - base, 0);
    prefix();
    busy = 1'b1; wr(18'h05555, 8'hA0); busy = 1'b0;
    wr(18'h00300, 8'h33);
    check("R10 busy resets tracker", req_cnt - base, 0);

    // R11 single-cycle pulses across the whole run
    check("R11 no double pulse", dbl_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule